// File: doc/BRIEF.md
# Clock-Stretching Two-Wire Serial Target

This block is the target side of a two-wire serial bus (I2C, 7-bit addressing) for a small auxiliary controller. It samples the clock and data lines through a two-flop synchroniser and finds bus edges on its own system clock. That clock must run at least eight times faster than the bus clock. The block never drives a line high. Each line has its own pull-low enable, and an external pull-up lifts the line when the enable is low.

After a START the block shifts in an address byte, most significant bit first. The byte carries seven address bits and then a direction bit. When the address matches `DEV_ADDR` the block drives the acknowledge bit. The local side handles data one byte at a time.

- **Controller writes:** each received byte is shown on `rx_byte_o` with `rx_valid_o` high, and the block holds the bus clock low.
- **Controller reads:** the block holds the clock low with `tx_req_o` high until the local side supplies the next byte.

In both cases one pulse on `byte_done_i` releases the clock. This lets slow local logic set the pace of the bus.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset, `scl_pull_o`, `sda_pull_o`, `rx_valid_o` and `tx_req_o` are all low.
- R2: When the byte after a START holds `DEV_ADDR` in its upper seven bits, the block pulls SDA low during the ninth clock pulse. A direction bit (bit 0) of 0 means the controller writes, and 1 means it reads.
- R3: When the address does not match, SDA stays released during the acknowledge bit. The block then ignores all traffic, raising neither `rx_valid_o` nor a clock hold, until the next START.
- R4: In a write, after the eighth bit of a data byte the block holds SCL low and raises `rx_valid_o`. The byte sits on `rx_byte_o` with the first bit received in bit 7. All of this stays in place until `byte_done_i` is seen.
- R5: A `byte_done_i` pulse during a write hold releases SCL, and SDA stays low as the acknowledge for the following clock pulse.
- R6: In a read, after the address acknowledge, the block holds SCL low and raises `tx_req_o`. A `byte_done_i` pulse loads `tx_byte_i` and releases SCL, and the byte is then sent on SDA starting with bit 7.
- R7: In a read, if the controller acknowledges a byte (SDA low on the ninth pulse), the block holds SCL again with `tx_req_o` high. If it does not acknowledge (SDA high), the block releases both lines and goes idle with no hold.
- R8: A STOP in the middle of a byte ends the transfer. Later clock pulses sent without a new START are ignored.
- R9: A START in the middle of a byte (a repeated START) discards the partial byte and begins a new address phase.
- R10: `byte_done_i` has no effect while the block is not holding SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_pull_o | output | 1 | 1 pulls the clock line low (stretch) |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| rx_byte_o | output | 8 | Last byte written by the controller |
| rx_valid_o | output | 1 | Write byte waiting for the local side |
| tx_byte_i | input | 8 | Next byte to send to the controller |
| tx_req_o | output | 1 | Read in progress, next byte wanted |
| byte_done_i | input | 1 | Local side has handled the byte |

## Verification
The bench builds the block with `DEV_ADDR` = 7'h42. With this value, the write address byte 8'h84 and the read address byte 8'h85 reach the matching paths. The byte 8'h86 differs from a match only in the last address bit, and 8'h02 differs in the upper bits, so both mismatch cases are covered. The bench runs the bus at 20 system clocks per half period, which gives the synchroniser and edge detector ample margin. A wired-AND model of the two lines lets the clock holds be observed as real bus pauses.

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch #(
  parameter logic [6:0] DEV_ADDR = 7'h42
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull_o,
  output logic       sda_pull_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_valid_o,
  input  logic [7:0] tx_byte_i,
  output logic       tx_req_o,
  input  logic       byte_done_i
);
  typedef enum logic [2:0] {IDLE, RXB, ACKB, HOLDW, HOLDR, TXB, MACK} st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [7:0] shreg;
  logic [3:0] bit_cnt;
  logic       is_addr, rd;

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  assign rx_valid_o = (st == HOLDW);
  assign tx_req_o   = (st == HOLDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      shreg      <= '0;
      bit_cnt    <= '0;
      is_addr    <= 1'b0;
      rd         <= 1'b0;
      rx_byte_o  <= '0;
      scl_pull_o <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (bus_stop) begin
      st         <= IDLE;
      bit_cnt    <= '0;
      scl_pull_o <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (bus_start) begin
      st         <= RXB;
      bit_cnt    <= '0;
      is_addr    <= 1'b1;
      scl_pull_o <= 1'b0;
      sda_pull_o <= 1'b0;
    end else begin
      unique case (st)
        IDLE: ;
        RXB: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            if (is_addr) begin
              if (shreg[7:1] == DEV_ADDR) begin
                rd         <= shreg[0];
                sda_pull_o <= 1'b1;
                st         <= ACKB;
              end else begin
                st <= IDLE;
              end
            end else begin
              rx_byte_o  <= shreg;
              sda_pull_o <= 1'b1;
              scl_pull_o <= 1'b1;
              st         <= HOLDW;
            end
          end
        end
        ACKB: begin
          if (scl_fall) begin
            sda_pull_o <= 1'b0;
            is_addr    <= 1'b0;
            if (rd) begin
              scl_pull_o <= 1'b1;
              st         <= HOLDR;
            end else begin
              st <= RXB;
            end
          end
        end
        HOLDW: begin
          if (byte_done_i) begin
            scl_pull_o <= 1'b0;
            st         <= ACKB;
          end
        end
        HOLDR: begin
          if (byte_done_i) begin
            shreg      <= tx_byte_i;
            sda_pull_o <= ~tx_byte_i[7];
            scl_pull_o <= 1'b0;
            bit_cnt    <= '0;
            st         <= TXB;
          end
        end
        TXB: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              bit_cnt    <= '0;
              sda_pull_o <= 1'b0;
              st         <= MACK;
            end else begin
              shreg      <= {shreg[6:0], 1'b0};
              sda_pull_o <= ~shreg[6];
            end
          end
        end
        MACK: begin
          if (scl_rise && sda_s) begin
            st <= IDLE;
          end else if (scl_fall) begin
            scl_pull_o <= 1'b1;
            st         <= HOLDR;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_target_stretch_chk.sv
module i2c_target_stretch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_pull_o,
  input logic       sda_pull_o,
  input logic       rx_valid_o,
  input logic       tx_req_o,
  input logic       byte_done_i,
  input logic [7:0] rx_byte_o
);
  a_r4_hold_means_pending: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_o |-> (rx_valid_o || tx_req_o));

  a_r4_pending_means_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o || tx_req_o) |-> scl_pull_o);

  a_r7_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid_o && tx_req_o));

  a_r4_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !byte_done_i) |=> (rx_valid_o && $stable(rx_byte_o)));

  a_r5_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && byte_done_i) |=> (!scl_pull_o && sda_pull_o));

  a_r6_sda_free_in_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |-> !sda_pull_o);
endmodule

bind i2c_target_stretch i2c_target_stretch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
  .rx_valid_o(rx_valid_o), .tx_req_o(tx_req_o), .byte_done_i(byte_done_i),
  .rx_byte_o(rx_byte_o)
);

// File: tb/i2c_target_stretch_tb_top.sv
module i2c_target_stretch_tb_top;
  localparam int HALF = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       done = 1'b0;
  logic       scl_line, sda_line;
  logic       scl_pull, sda_pull, rx_valid, tx_req;
  logic [7:0] rx_byte;
  int         checks = 0, errors = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  assign scl_line = ~(m_scl_low | scl_pull);
  assign sda_line = ~(m_sda_low | sda_pull);

  i2c_target_stretch #(.DEV_ADDR(7'h42)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .rx_byte_o(rx_byte),
    .rx_valid_o(rx_valid), .tx_byte_i(tx_byte), .tx_req_o(tx_req),
    .byte_done_i(done)
  );

  // {first byte, data byte, acknowledge expected}
  localparam logic [16:0] VEC [6] = '{
    {8'h84, 8'hA5, 1'b1}, {8'h86, 8'h11, 1'b0}, {8'h84, 8'h3C, 1'b1},
    {8'h02, 8'hFF, 1'b0}, {8'h84, 8'hFF, 1'b1}, {8'h84, 8'h00, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; tick(HALF);
    m_scl_low = 1'b0; wait (scl_line); tick(HALF);
    m_sda_low = 1'b1; tick(HALF);
    m_scl_low = 1'b1; tick(HALF);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; tick(HALF);
    m_scl_low = 1'b0; wait (scl_line); tick(HALF);
    m_sda_low = 1'b0; tick(HALF);
  endtask

  task automatic send_bit(input logic b);
    m_sda_low = ~b; tick(HALF);
    m_scl_low = 1'b0; wait (scl_line); @(negedge clk); tick(HALF);
    m_scl_low = 1'b1; tick(HALF);
  endtask

  task automatic recv_bit(output logic b);
    m_sda_low = 1'b0; tick(HALF);
    m_scl_low = 1'b0; wait (scl_line); @(negedge clk); tick(HALF / 2);
    b = sda_line; tick(HALF / 2);
    m_scl_low = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
  endtask

  task automatic pulse_done();
    done = 1'b1; tick(1); done = 1'b0; tick(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic       a;
    logic [7:0] got;
    tick(4);
    chk("R1 scl_pull", scl_pull, 0); chk("R1 sda_pull", sda_pull, 0);
    chk("R1 rx_valid", rx_valid, 0); chk("R1 tx_req", tx_req, 0);
    rst_n = 1'b1; tick(5);

    foreach (VEC[k]) begin
      bus_start();
      send_byte(VEC[k][16:9]);
      recv_bit(a);
      if (VEC[k][0]) begin
        chk("R2 address ack", a, 0);
        send_byte(VEC[k][8:1]);
        chk("R4 hold", scl_pull, 1); chk("R4 rx_valid", rx_valid, 1);
        chk("R4 rx_byte", rx_byte, VEC[k][8:1]);
        tick(40);
        chk("R4 still held", scl_pull, 1); chk("R4 byte stable", rx_byte, VEC[k][8:1]);
        pulse_done();
        chk("R5 released", scl_pull, 0);
        recv_bit(a);
        chk("R5 data ack", a, 0);
      end else begin
        chk("R3 no address ack", a, 1);
        send_byte(VEC[k][8:1]);
        chk("R3 no rx_valid", rx_valid, 0); chk("R3 no hold", scl_pull, 0);
        recv_bit(a);
        chk("R3 no data ack", a, 1);
      end
      bus_stop();
    end

    // R6/R7: read two bytes, acknowledge first, refuse second
    bus_start(); send_byte(8'h85); recv_bit(a);
    chk("R2 read address ack", a, 0);
    chk("R6 tx_req", tx_req, 1); chk("R6 hold", scl_pull, 1);
    tx_byte = 8'hC3; pulse_done(); tx_byte = 8'h00;
    chk("R6 released", scl_pull, 0);
    recv_byte(got); chk("R6 first byte", got, 8'hC3);
    send_bit(1'b0);
    chk("R7 ack rehold", scl_pull, 1); chk("R7 ack tx_req", tx_req, 1);
    tx_byte = 8'h5A; pulse_done();
    recv_byte(got); chk("R6 second byte", got, 8'h5A);
    send_bit(1'b1);
    chk("R7 nack no tx_req", tx_req, 0); chk("R7 nack no hold", scl_pull, 0);
    chk("R7 nack sda free", sda_pull, 0);
    bus_stop();

    // R10 then R8: stray done, then STOP mid-byte
    bus_start(); send_byte(8'h84); recv_bit(a);
    pulse_done();
    chk("R10 stray done no release", scl_pull, 0);
    send_byte(8'h96);
    chk("R10 hold survives stray done", scl_pull, 1); chk("R10 byte", rx_byte, 8'h96);
    pulse_done(); recv_bit(a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    m_scl_low = 1'b1; tick(HALF);
    send_byte(8'h84);
    chk("R8 no rx_valid after stop", rx_valid, 0); chk("R8 no hold after stop", scl_pull, 0);
    recv_bit(a); chk("R8 no ack after stop", a, 1);
    bus_stop();

    // R9: repeated START mid-byte
    bus_start(); send_byte(8'h84); recv_bit(a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start(); send_byte(8'h84); recv_bit(a);
    chk("R9 new address ack", a, 0);
    send_byte(8'h77);
    chk("R9 rx_valid", rx_valid, 1); chk("R9 rx_byte", rx_byte, 8'h77);
    pulse_done(); recv_bit(a);
    bus_stop();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule